// File: doc/BRIEF.md
# Performance counter software-increment unit

This block holds a bank of programmable 32-bit event counters that advance only when software asks them to. A bus write to the increment register carries one request bit per counter. A counter advances by exactly one when three conditions hold together: its request bit is set, its enable bit is set, and its event-type field holds the software-increment code, which is zero. A counter that steps from all ones to zero sets its bit in the overflow status register. All qualifying counters named in one write advance in the same clock cycle.

The block also contains the support registers that go with the counters. Each counter has a directly readable and writable value register and an event-type register. The enable bits and the overflow bits each sit behind a write-1-to-set address and a write-1-to-clear address. The increment register is write-only. A read of it returns an error flag instead of data.

The number of counters `NCNT` is a parameter, with a default of 6 and a maximum of 31. Bit positions at `NCNT` and above have no effect when written and read as zero in every bitmask register. These counters are not driven by any hardware event.

Top module: `swinc_pmu`

## Requirements
- R1: After a synchronous reset, all counter values, event types, enable bits and overflow bits read as zero.
- R2: A write of mask M to the increment address (0x44) advances counter i by exactly one when M[i] is 1, enable bit i is 1, and type register i is 0. Every such counter advances in the same cycle.
- R3: A counter whose enable bit is 0, or whose type register is non-zero, keeps its value when its bit is set in an increment write.
- R4: A counter at 0xFFFFFFFF that is incremented becomes 0x00000000, and overflow bit i becomes 1. No other overflow bit changes.
- R5: A read of the increment address returns rd_err = 1 with rdata = 0 in the cycle after rd_en. A read of any other address returns rd_err = 0.
- R6: Write-data bits at positions NCNT and above have no effect on the increment, enable and overflow registers. Those bit positions read as 0.
- R7: An increment write whose low NCNT bits are all zero changes no counter and no overflow bit.
- R8: Writing 1s to address 0x40 sets enable bits and writing 1s to 0x41 clears them. Addresses 0x42 and 0x43 do the same for the overflow bits. A read of either address in a pair returns that register.
- R9: Counter i is read and written at address 0x00+i. Type register i is read and written at 0x20+i. A type register stores bits [9:0] of the write data, and its higher read bits are 0.
- R10: rdata is valid in the cycle after rd_en. When a read and a write hit the same register in the same cycle, the read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one register per cycle |
| rd_en | input | 1 | Read strobe |
| addr | input | 7 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data, 0 when no read was issued |
| rd_err | output | 1 | Registered undefined-access flag for a read of the increment address |

## Verification
The bench sweeps all 64 increment masks under two enable patterns, with one counter given a non-zero event type and junk in the upper write bits. A design that ignores the enable bit, ignores the type check, or lets bits above NCNT through would show a counter that drifts away from the arithmetic model in the bench. Counters preset to 0xFFFFFFFF and 0xFFFFFFFE check that only the wrapping counter posts overflow and that the value truncates to zero. A design that flags overflow at the wrong count, or keeps a carry, fails here. Further checks read the increment address, which must return the error flag and no data, and read and write one register in the same cycle, which must return the old value.

// File: rtl/swinc_pkg.sv
package swinc_pkg;
  localparam int ADDR_W = 7;
  localparam logic [ADDR_W-1:0] A_CNT_BASE  = 7'h00;
  localparam logic [ADDR_W-1:0] A_TYPE_BASE = 7'h20;
  localparam logic [ADDR_W-1:0] A_EN_SET    = 7'h40;
  localparam logic [ADDR_W-1:0] A_EN_CLR    = 7'h41;
  localparam logic [ADDR_W-1:0] A_OV_SET    = 7'h42;
  localparam logic [ADDR_W-1:0] A_OV_CLR    = 7'h43;
  localparam logic [ADDR_W-1:0] A_SWINC     = 7'h44;
endpackage

// File: rtl/swinc_bitreg.sv
module swinc_bitreg #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_v,
  input  logic [N-1:0] clr_v,
  output logic [N-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= (q & ~clr_v) | set_v;
  end

  assert_set_R8: assert property (@(posedge clk) disable iff (rst)
    (set_v != '0) |=> ((q & $past(set_v)) == $past(set_v)));
  assert_clr_R8: assert property (@(posedge clk) disable iff (rst)
    (clr_v != '0 && set_v == '0) |=> ((q & $past(clr_v)) == '0));
endmodule

// File: rtl/swinc_counter.sv
module swinc_counter #(
  parameter int CW  = 32,
  parameter int EVW = 10
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cnt_we,
  input  logic           type_we,
  input  logic [CW-1:0]  wdata,
  input  logic           inc_req,
  output logic [CW-1:0]  cnt,
  output logic [EVW-1:0] evtype,
  output logic           wrap
);
  logic is_sw;
  logic step;

  assign is_sw = (evtype == '0);
  assign step  = inc_req && is_sw;
  assign wrap  = step && (&cnt);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      evtype <= '0;
    end else begin
      if (cnt_we)      cnt <= wdata;
      else if (step)   cnt <= cnt + 1'b1;
      if (type_we)     evtype <= wdata[EVW-1:0];
    end
  end

  assert_step_R2: assert property (@(posedge clk) disable iff (rst)
    (inc_req && !cnt_we && evtype == '0) |=> (cnt == $past(cnt) + 1'b1));
  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!cnt_we && evtype != '0) |=> $stable(cnt));
  assert_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (cnt == '0));
endmodule

// File: rtl/swinc_pmu.sv
module swinc_pmu
  import swinc_pkg::*;
#(
  parameter int NCNT = 6,
  parameter int DW   = 32,
  parameter int EVW  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic              rd_err
);
  localparam int IDX_W = 5;

  logic [IDX_W-1:0] idx;
  logic             in_cnt, in_type, idx_ok;
  logic [NCNT-1:0]  wmask;
  logic [NCNT-1:0]  en_q, ov_q;
  logic [NCNT-1:0]  en_set, en_clr, ov_set, ov_clr;
  logic [NCNT-1:0]  sw_req, wrap_v;
  logic [DW-1:0]    cnt_v  [NCNT];
  logic [EVW-1:0]   type_v [NCNT];
  logic [DW-1:0]    rd_mux;

  assign idx     = addr[IDX_W-1:0];
  assign idx_ok  = (32'(idx) < NCNT);
  assign in_cnt  = (addr[ADDR_W-1:IDX_W] == A_CNT_BASE[ADDR_W-1:IDX_W]);
  assign in_type = (addr[ADDR_W-1:IDX_W] == A_TYPE_BASE[ADDR_W-1:IDX_W]);
  assign wmask   = wdata[NCNT-1:0];

  assign en_set = (wr_en && addr == A_EN_SET) ? wmask : '0;
  assign en_clr = (wr_en && addr == A_EN_CLR) ? wmask : '0;
  assign ov_set = ((wr_en && addr == A_OV_SET) ? wmask : '0) | wrap_v;
  assign ov_clr = (wr_en && addr == A_OV_CLR) ? wmask : '0;
  assign sw_req = (wr_en && addr == A_SWINC) ? (wmask & en_q) : '0;

  swinc_bitreg #(.N(NCNT)) u_en (
    .clk(clk), .rst(rst), .set_v(en_set), .clr_v(en_clr), .q(en_q));
  swinc_bitreg #(.N(NCNT)) u_ov (
    .clk(clk), .rst(rst), .set_v(ov_set), .clr_v(ov_clr), .q(ov_q));

  for (genvar i = 0; i < NCNT; i++) begin : g_cnt
    swinc_counter #(.CW(DW), .EVW(EVW)) u_c (
      .clk     (clk),
      .rst     (rst),
      .cnt_we  (wr_en && in_cnt  && idx == IDX_W'(i)),
      .type_we (wr_en && in_type && idx == IDX_W'(i)),
      .wdata   (wdata),
      .inc_req (sw_req[i]),
      .cnt     (cnt_v[i]),
      .evtype  (type_v[i]),
      .wrap    (wrap_v[i])
    );
  end

  always_comb begin
    rd_mux = '0;
    if (in_cnt && idx_ok)       rd_mux = cnt_v[idx];
    else if (in_type && idx_ok) rd_mux = DW'(type_v[idx]);
    else if (addr == A_EN_SET || addr == A_EN_CLR) rd_mux = DW'(en_q);
    else if (addr == A_OV_SET || addr == A_OV_CLR) rd_mux = DW'(ov_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rd_err <= 1'b0;
    end else begin
      rdata  <= rd_en ? rd_mux : '0;
      rd_err <= rd_en && (addr == A_SWINC);
    end
  end

  assert_err_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == A_SWINC) |=> (rd_err && rdata == '0));
  assert_upper_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (addr == A_EN_SET || addr == A_OV_SET)) |=> ((rdata >> NCNT) == '0));
  assert_zero_noop_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_SWINC && wdata[NCNT-1:0] == '0) |=> $stable(ov_q));
endmodule

// File: tb/tb_swinc_pmu.sv
`timescale 1ns/1ps
module tb_swinc_pmu;
  localparam int N = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [6:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rd_err;

  int checks = 0, fails = 0;
  logic [31:0] ecnt [N];
  logic [9:0]  ety  [N];
  logic [N-1:0] een, eov;

  always #2 clk = ~clk;

  swinc_pmu dut (.clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
                 .addr(addr), .wdata(wdata), .rdata(rdata), .rd_err(rd_err));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d, output logic e);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata; e = rd_err;
  endtask

  task automatic rchk(input string tag, input logic [6:0] a, input logic [31:0] exp);
    logic [31:0] d; logic e;
    rd(a, d, e);
    chk(tag, d, exp);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] d; logic e;
    logic [31:0] wv;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    for (int i = 0; i < N; i++) begin
      rchk("R1 counter", 7'(i), 32'h0);
      rchk("R1 type", 7'(32 + i), 32'h0);
    end
    rchk("R1 enable", 7'h40, 32'h0);
    rchk("R1 overflow", 7'h42, 32'h0);

    // R8 enable set/clear aliases, R6 upper bits ignored
    wr(7'h40, 32'hFFFF_FFFF);
    rchk("R6 R8 enable set", 7'h41, 32'h3F);
    wr(7'h41, 32'hFFFF_FFC5);
    rchk("R8 enable clear", 7'h40, 32'h3A);

    // R9 type width and readback
    wr(7'h21, 32'hFFFF_FFFF);
    rchk("R9 type truncation", 7'h21, 32'h3FF);
    wr(7'h21, 32'h11);
    rchk("R9 type write", 7'h21, 32'h11);

    for (int i = 0; i < N; i++) begin ecnt[i] = 0; ety[i] = 0; end
    ety[1] = 10'h11;

    // R2 R3 R6 R7 sweep of all masks under two enable patterns
    for (int ph = 0; ph < 2; ph++) begin
      een = (ph == 0) ? 6'h3F : 6'h2D;
      wr(7'h41, 32'h3F);
      wr(7'h40, {26'h0, een});
      for (int m = 0; m < 64; m++) begin
        wv = ((32'(m) * 32'h9E37_79B1) & 32'hFFFF_FFC0) | 32'(m);
        wr(7'h44, wv);
        for (int i = 0; i < N; i++)
          if (m[i] && een[i] && ety[i] == 0) ecnt[i] = ecnt[i] + 1;
        for (int i = 0; i < N; i++)
          rchk("R2 R3 R7 counter after increment", 7'(i), ecnt[i]);
      end
      rchk("R7 no overflow in sweep", 7'h42, 32'h0);
    end

    // R4 wrap and overflow
    wr(7'h21, 32'h0);
    wr(7'h40, 32'h3F);
    wr(7'h02, 32'hFFFF_FFFF);
    wr(7'h03, 32'hFFFF_FFFE);
    wr(7'h44, 32'h0000_000C);
    rchk("R4 wrapped counter", 7'h02, 32'h0);
    rchk("R4 non-wrapped counter", 7'h03, 32'hFFFF_FFFF);
    rchk("R4 overflow bit", 7'h43, 32'h4);
    wr(7'h44, 32'h0000_0008);
    rchk("R4 second wrap", 7'h03, 32'h0);
    rchk("R4 overflow accumulates", 7'h42, 32'hC);
    wr(7'h43, 32'h4);
    rchk("R8 overflow clear", 7'h42, 32'h8);
    wr(7'h42, 32'hFFFF_FF01);
    rchk("R6 R8 overflow set", 7'h42, 32'h9);

    // R5 undefined read
    rd(7'h44, d, e);
    chk("R5 error flag", 32'(e), 32'h1);
    chk("R5 no data", d, 32'h0);
    rd(7'h00, d, e);
    chk("R5 no error on counter read", 32'(e), 32'h0);

    // R10 same-cycle read and write
    wr(7'h05, 32'h1234_5678);
    @(negedge clk); wr_en = 1'b1; rd_en = 1'b1; addr = 7'h05; wdata = 32'hCAFE_0001;
    @(negedge clk); wr_en = 1'b0; rd_en = 1'b0;
    chk("R10 read returns old value", rdata, 32'h1234_5678);
    rchk("R10 then new value", 7'h05, 32'hCAFE_0001);

    summary();
  end
endmodule